// File: doc/BRIEF.md
# Stacked-Layer Hit Column Correlator

This block pairs pixel hits from two closely spaced sensor layers so that only short, steep track stubs move on to the trigger. Each layer delivers its own hit stream, sorted by ascending column within a crossing and closed by an end-of-crossing beat. The block walks both streams the way a merge does. At each step it compares the two head columns, drops the head that has fallen behind the other by more than the search window, and passes on a pair when the two columns lie within the window. A bypass input turns the walk into a plain sorted merge that forwards every hit, which suits runs with low occupancy.

Every hit the walk consumes is also written, tagged with its layer, into a fixed-depth latency buffer. The walk also writes a marker entry at the end of each crossing. A separate decision stream resolves the buffered crossings oldest first. A kept crossing is read out hit by hit and then closed with a last beat. A rejected crossing is discarded without output.

All data interfaces are valid/ready. A beat moves on a clock edge where valid and ready are both high. A source must hold valid and its data until that edge. The walk performs a step only when both stream heads are present, the trigger output register is empty or being drained, and the latency buffer has room. Otherwise both input readies stay low. The bypass input is a plain level, and it may change only while no crossing is in flight.

Top module: `stub_correlator`

## Requirements
- R1: With both heads holding hits outside bypass, an outer column greater than the inner column plus WIN (default 1) discards the inner head and consumes only the inner stream. The outer head stays and can pair with the next inner hit.
- R2: With both heads holding hits outside bypass, an outer column plus WIN below the inner column discards the outer head and consumes only the outer stream.
- R3: When the two columns differ by at most WIN, one trigger beat of kind 3 carries both hits, and only the inner stream is consumed. The same outer hit can then pair with the following inner hit.
- R4: With the default window, column differences of 0 and 1 in either direction form a pair, and a difference of 2 does not.
- R5: Once one stream shows its end-of-crossing beat, the remaining hits of the other stream are consumed one per step. Outside bypass they produce no trigger beat.
- R6: When both heads are end-of-crossing beats, they are consumed in the same cycle, and one trigger beat of kind 0 with zero hit fields is produced. No other step consumes both streams at once.
- R7: In bypass mode every hit is forwarded as a single trigger beat in ascending column order. An inner hit uses kind 1 with the hit in the inner field, and an outer hit uses kind 2 with the hit in the outer field. The inner hit goes first on a column tie.
- R8: A hit is COL_W+ROW_W = 20 bits, with the column in bits 19:10 and the row in bits 9:0. Only the column takes part in the comparisons.
- R9: While trigger valid is high and trigger ready is low, the trigger beat stays unchanged, and no further step that needs the output is taken.
- R10: Every consumed hit enters the latency buffer in consumption order, tagged with its layer (0 for inner, 1 for outer). A kept crossing reads out those hits in that order with last low.
- R11: Each decision applies to the oldest unresolved crossing. For keep=1, the crossing's hits are followed by one beat with last high and zero hit. The decision is taken together with that last beat. For keep=0, the crossing produces no readout beat.
- R12: When the latency buffer holds BUF_DEPTH entries, the walk stalls with both input readies low, and no entry is lost.
- R13: During reset, trigger valid, readout valid and both input readies are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bypass | input | 1 | Forward all hits without correlation |
| inr_valid | input | 1 | Inner stream beat present |
| inr_ready | output | 1 | Inner stream beat consumed |
| inr_eoc | input | 1 | Inner beat is the end-of-crossing marker |
| inr_hit | input | 20 | Inner hit address, column in the upper bits |
| otr_valid | input | 1 | Outer stream beat present |
| otr_ready | output | 1 | Outer stream beat consumed |
| otr_eoc | input | 1 | Outer beat is the end-of-crossing marker |
| otr_hit | input | 20 | Outer hit address, column in the upper bits |
| trg_valid | output | 1 | Trigger beat present |
| trg_ready | input | 1 | Trigger sink accepts the beat |
| trg_kind | output | 2 | 0 end, 1 inner only, 2 outer only, 3 pair |
| trg_inner | output | 20 | Inner hit of the beat |
| trg_outer | output | 20 | Outer hit of the beat |
| dec_valid | input | 1 | Crossing decision present |
| dec_ready | output | 1 | Decision consumed |
| dec_keep | input | 1 | 1 reads the crossing out, 0 discards it |
| rd_valid | output | 1 | Readout beat present |
| rd_ready | input | 1 | Readout sink accepts the beat |
| rd_last | output | 1 | Closing beat of a kept crossing |
| rd_layer | output | 1 | 0 inner, 1 outer |
| rd_hit | output | 20 | Buffered hit address |

## Verification
A walk step can fall in the same cycle as a stalled trigger output. It can also fall in the same cycle as a latency-buffer pop driven by a decision. The bench toggles both sink readies at random, so steps meet held trigger beats and readout drains in the same edge. For these cycles it checks that every held trigger beat stays unchanged and that the scoreboard order holds. A final phase holds all decisions back until the buffer fills. At that point it checks that both input readies stay low, and it then releases the decisions. Every consumed hit must still appear, in order, for the kept crossings.

// File: rtl/stub_pkg.sv
`timescale 1ns/1ps
package stub_pkg;

  typedef enum logic [1:0] {
    KIND_END   = 2'b00,
    KIND_INNER = 2'b01,
    KIND_OUTER = 2'b10,
    KIND_PAIR  = 2'b11
  } trg_kind_e;

  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_CLOSE,
    ACT_DROP_IN,
    ACT_DROP_OUT,
    ACT_PAIR,
    ACT_PASS_IN,
    ACT_PASS_OUT
  } step_e;

endpackage

// File: rtl/stub_window_cmp.sv
`timescale 1ns/1ps
module stub_window_cmp #(
  parameter int COL_W = 10,
  parameter int WIN   = 1
) (
  input  logic [COL_W-1:0] col_inner,
  input  logic [COL_W-1:0] col_outer,
  output logic             outer_ahead,
  output logic             outer_behind
);

  localparam int EXT_W = COL_W + 1;
  localparam logic [EXT_W-1:0] WIN_X = EXT_W'(WIN);

  logic [EXT_W-1:0] ci_x;
  logic [EXT_W-1:0] co_x;

  assign ci_x = {1'b0, col_inner};
  assign co_x = {1'b0, col_outer};

  generate
    if (WIN == 0) begin : g_exact
      assign outer_ahead  = co_x > ci_x;
      assign outer_behind = co_x < ci_x;
    end else begin : g_window
      assign outer_ahead  = co_x > (ci_x + WIN_X);
      assign outer_behind = (co_x + WIN_X) < ci_x;
    end
  endgenerate

endmodule

// File: rtl/stub_walker.sv
`timescale 1ns/1ps
module stub_walker
  import stub_pkg::*;
#(
  parameter int COL_W = 10,
  parameter int ROW_W = 10,
  parameter int WIN   = 1
) (
  input  logic                   bypass,
  input  logic                   inr_valid,
  input  logic                   inr_eoc,
  input  logic [COL_W+ROW_W-1:0] inr_hit,
  input  logic                   otr_valid,
  input  logic                   otr_eoc,
  input  logic [COL_W+ROW_W-1:0] otr_hit,
  input  logic                   slot_free,
  input  logic                   buf_room,
  output logic                   inr_take,
  output logic                   otr_take,
  output logic                   emit_en,
  output trg_kind_e              emit_kind,
  output logic [COL_W+ROW_W-1:0] emit_inner,
  output logic [COL_W+ROW_W-1:0] emit_outer,
  output logic                   wr_en,
  output logic                   wr_mark,
  output logic                   wr_layer,
  output logic [COL_W+ROW_W-1:0] wr_hit
);

  localparam int HIT_W = COL_W + ROW_W;

  logic [COL_W-1:0] col_i;
  logic [COL_W-1:0] col_o;
  logic             outer_ahead;
  logic             outer_behind;
  step_e            act;
  logic             go;

  assign col_i = inr_hit[HIT_W-1 -: COL_W];
  assign col_o = otr_hit[HIT_W-1 -: COL_W];

  stub_window_cmp #(
    .COL_W (COL_W),
    .WIN   (WIN)
  ) u_win (
    .col_inner    (col_i),
    .col_outer    (col_o),
    .outer_ahead  (outer_ahead),
    .outer_behind (outer_behind)
  );

  always_comb begin
    act = ACT_IDLE;
    if (inr_valid && otr_valid) begin
      if (inr_eoc && otr_eoc)   act = ACT_CLOSE;
      else if (inr_eoc)         act = bypass ? ACT_PASS_OUT : ACT_DROP_OUT;
      else if (otr_eoc)         act = bypass ? ACT_PASS_IN  : ACT_DROP_IN;
      else if (bypass)          act = (col_o < col_i) ? ACT_PASS_OUT : ACT_PASS_IN;
      else if (outer_ahead)     act = ACT_DROP_IN;
      else if (outer_behind)    act = ACT_DROP_OUT;
      else                      act = ACT_PAIR;
    end
  end

  assign go = (act != ACT_IDLE) && slot_free && buf_room;

  always_comb begin
    inr_take   = 1'b0;
    otr_take   = 1'b0;
    emit_en    = 1'b0;
    emit_kind  = KIND_END;
    emit_inner = '0;
    emit_outer = '0;
    wr_en      = go;
    wr_mark    = 1'b0;
    wr_layer   = 1'b0;
    wr_hit     = '0;
    if (go) begin
      unique case (act)
        ACT_CLOSE: begin
          inr_take = 1'b1;
          otr_take = 1'b1;
          emit_en  = 1'b1;
          wr_mark  = 1'b1;
        end
        ACT_DROP_IN: begin
          inr_take = 1'b1;
          wr_hit   = inr_hit;
        end
        ACT_DROP_OUT: begin
          otr_take = 1'b1;
          wr_layer = 1'b1;
          wr_hit   = otr_hit;
        end
        ACT_PAIR: begin
          inr_take   = 1'b1;
          emit_en    = 1'b1;
          emit_kind  = KIND_PAIR;
          emit_inner = inr_hit;
          emit_outer = otr_hit;
          wr_hit     = inr_hit;
        end
        ACT_PASS_IN: begin
          inr_take   = 1'b1;
          emit_en    = 1'b1;
          emit_kind  = KIND_INNER;
          emit_inner = inr_hit;
          wr_hit     = inr_hit;
        end
        ACT_PASS_OUT: begin
          otr_take   = 1'b1;
          emit_en    = 1'b1;
          emit_kind  = KIND_OUTER;
          emit_outer = otr_hit;
          wr_layer   = 1'b1;
          wr_hit     = otr_hit;
        end
        default: begin
          wr_en = 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/stub_accept_buf.sv
`timescale 1ns/1ps
module stub_accept_buf #(
  parameter int HIT_W = 20,
  parameter int DEPTH = 512
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic                         wr_mark,
  input  logic                         wr_layer,
  input  logic [HIT_W-1:0]             wr_hit,
  output logic                         has_room,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  input  logic                         dec_valid,
  input  logic                         dec_keep,
  output logic                         dec_ready,
  output logic                         rd_valid,
  input  logic                         rd_ready,
  output logic                         rd_last,
  output logic                         rd_layer,
  output logic [HIT_W-1:0]             rd_hit
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int ENT_W = HIT_W + 2;
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

  logic [ENT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr;
  logic [PTR_W-1:0] rptr;
  logic [CNT_W-1:0] count;
  logic [ENT_W-1:0] head;
  logic             head_valid;
  logic             active;
  logic             pop;
  logic             h_mark;

  assign head       = mem[rptr];
  assign h_mark     = head[ENT_W-1];
  assign head_valid = (count != '0);
  assign has_room   = (count != CNT_FULL);
  assign level      = count;

  assign active    = head_valid && dec_valid;
  assign rd_valid  = active && dec_keep;
  assign rd_last   = h_mark;
  assign rd_layer  = h_mark ? 1'b0 : head[ENT_W-2];
  assign rd_hit    = h_mark ? '0 : head[HIT_W-1:0];
  assign pop       = active && (!dec_keep || rd_ready);
  assign dec_ready = pop && h_mark;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= {wr_mark, wr_layer, wr_hit};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (pop)   rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      count <= count + CNT_W'(wr_en) - CNT_W'(pop);
    end
  end

endmodule

// File: rtl/stub_correlator.sv
`timescale 1ns/1ps
module stub_correlator
  import stub_pkg::*;
#(
  parameter int COL_W     = 10,
  parameter int ROW_W     = 10,
  parameter int WIN       = 1,
  parameter int BUF_DEPTH = 512
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bypass,
  input  logic                   inr_valid,
  output logic                   inr_ready,
  input  logic                   inr_eoc,
  input  logic [COL_W+ROW_W-1:0] inr_hit,
  input  logic                   otr_valid,
  output logic                   otr_ready,
  input  logic                   otr_eoc,
  input  logic [COL_W+ROW_W-1:0] otr_hit,
  output logic                   trg_valid,
  input  logic                   trg_ready,
  output logic [1:0]             trg_kind,
  output logic [COL_W+ROW_W-1:0] trg_inner,
  output logic [COL_W+ROW_W-1:0] trg_outer,
  input  logic                   dec_valid,
  output logic                   dec_ready,
  input  logic                   dec_keep,
  output logic                   rd_valid,
  input  logic                   rd_ready,
  output logic                   rd_last,
  output logic                   rd_layer,
  output logic [COL_W+ROW_W-1:0] rd_hit
);

  localparam int HIT_W = COL_W + ROW_W;
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);

  logic             slot_free;
  logic             buf_room;
  logic             emit_en;
  trg_kind_e        emit_kind;
  logic [HIT_W-1:0] emit_inner;
  logic [HIT_W-1:0] emit_outer;
  logic             wr_en;
  logic             wr_mark;
  logic             wr_layer;
  logic [HIT_W-1:0] wr_hit;
  logic [CNT_W-1:0] buf_level;

  assign slot_free = rst_n && (!trg_valid || trg_ready);

  stub_walker #(
    .COL_W (COL_W),
    .ROW_W (ROW_W),
    .WIN   (WIN)
  ) u_walk (
    .bypass     (bypass),
    .inr_valid  (inr_valid),
    .inr_eoc    (inr_eoc),
    .inr_hit    (inr_hit),
    .otr_valid  (otr_valid),
    .otr_eoc    (otr_eoc),
    .otr_hit    (otr_hit),
    .slot_free  (slot_free),
    .buf_room   (buf_room),
    .inr_take   (inr_ready),
    .otr_take   (otr_ready),
    .emit_en    (emit_en),
    .emit_kind  (emit_kind),
    .emit_inner (emit_inner),
    .emit_outer (emit_outer),
    .wr_en      (wr_en),
    .wr_mark    (wr_mark),
    .wr_layer   (wr_layer),
    .wr_hit     (wr_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trg_valid <= 1'b0;
      trg_kind  <= KIND_END;
      trg_inner <= '0;
      trg_outer <= '0;
    end else if (emit_en) begin
      trg_valid <= 1'b1;
      trg_kind  <= emit_kind;
      trg_inner <= emit_inner;
      trg_outer <= emit_outer;
    end else if (trg_ready) begin
      trg_valid <= 1'b0;
    end
  end

  stub_accept_buf #(
    .HIT_W (HIT_W),
    .DEPTH (BUF_DEPTH)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_mark   (wr_mark),
    .wr_layer  (wr_layer),
    .wr_hit    (wr_hit),
    .has_room  (buf_room),
    .level     (buf_level),
    .dec_valid (dec_valid),
    .dec_keep  (dec_keep),
    .dec_ready (dec_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_last   (rd_last),
    .rd_layer  (rd_layer),
    .rd_hit    (rd_hit)
  );

endmodule

// File: rtl/stub_correlator_chk.sv
`timescale 1ns/1ps
module stub_correlator_chk
  import stub_pkg::*;
#(
  parameter int COL_W     = 10,
  parameter int ROW_W     = 10,
  parameter int WIN       = 1,
  parameter int BUF_DEPTH = 512
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           inr_valid,
  input logic                           inr_ready,
  input logic                           inr_eoc,
  input logic                           otr_valid,
  input logic                           otr_ready,
  input logic                           otr_eoc,
  input logic                           trg_valid,
  input logic                           trg_ready,
  input logic [1:0]                     trg_kind,
  input logic [COL_W+ROW_W-1:0]         trg_inner,
  input logic [COL_W+ROW_W-1:0]         trg_outer,
  input logic                           dec_valid,
  input logic                           dec_ready,
  input logic                           dec_keep,
  input logic                           rd_valid,
  input logic                           rd_ready,
  input logic                           rd_last,
  input logic [$clog2(BUF_DEPTH+1)-1:0] buf_level
);

  localparam int HIT_W = COL_W + ROW_W;
  localparam int EXT_W = COL_W + 1;
  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam logic [EXT_W-1:0] WIN_X = EXT_W'(WIN);
  localparam logic [CNT_W-1:0] FULL  = CNT_W'(BUF_DEPTH);

  logic [EXT_W-1:0] pci;
  logic [EXT_W-1:0] pco;
  logic             in_fire;
  logic             out_fire;

  assign pci      = {1'b0, trg_inner[HIT_W-1 -: COL_W]};
  assign pco      = {1'b0, trg_outer[HIT_W-1 -: COL_W]};
  assign in_fire  = inr_valid && inr_ready;
  assign out_fire = otr_valid && otr_ready;

  AST_TRG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    trg_valid && !trg_ready |=> trg_valid && $stable(trg_kind) && $stable(trg_inner) && $stable(trg_outer)); // R9

  AST_PAIR_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    trg_valid && (trg_kind == KIND_PAIR) |-> (pco <= pci + WIN_X) && (pco + WIN_X >= pci)); // R3

  AST_JOINT_STEP_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    in_fire && out_fire |-> inr_eoc && otr_eoc); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    buf_level <= FULL); // R12

  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    buf_level == FULL |-> !in_fire && !out_fire); // R12

  AST_KEEP_CLOSES_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid && dec_ready && dec_keep |-> rd_valid && rd_ready && rd_last); // R11

endmodule

bind stub_correlator stub_correlator_chk #(
  .COL_W     (COL_W),
  .ROW_W     (ROW_W),
  .WIN       (WIN),
  .BUF_DEPTH (BUF_DEPTH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .inr_valid (inr_valid),
  .inr_ready (inr_ready),
  .inr_eoc   (inr_eoc),
  .otr_valid (otr_valid),
  .otr_ready (otr_ready),
  .otr_eoc   (otr_eoc),
  .trg_valid (trg_valid),
  .trg_ready (trg_ready),
  .trg_kind  (trg_kind),
  .trg_inner (trg_inner),
  .trg_outer (trg_outer),
  .dec_valid (dec_valid),
  .dec_ready (dec_ready),
  .dec_keep  (dec_keep),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_last   (rd_last),
  .buf_level (buf_level)
);

// File: tb/test_stub_correlator.sv
`timescale 1ns/1ps
module test_stub_correlator;
  import stub_pkg::*;

  localparam int COL_W = 10;
  localparam int ROW_W = 10;
  localparam int HIT_W = COL_W + ROW_W;
  localparam int WIN   = 1;
  localparam int DEPTH = 512;

  typedef struct {
    logic [1:0]       kind;
    logic [HIT_W-1:0] hi;
    logic [HIT_W-1:0] ho;
    string            tag;
  } trg_exp_t;

  typedef struct {
    logic             last;
    logic             layer;
    logic [HIT_W-1:0] hit;
    string            tag;
  } rd_exp_t;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, bypass = 1'b0;
  logic inr_valid = 1'b0, inr_eoc = 1'b0, otr_valid = 1'b0, otr_eoc = 1'b0;
  logic [HIT_W-1:0] inr_hit = '0, otr_hit = '0;
  logic inr_ready, otr_ready;
  logic trg_valid, trg_ready = 1'b0;
  logic [1:0] trg_kind;
  logic [HIT_W-1:0] trg_inner, trg_outer;
  logic dec_valid = 1'b0, dec_keep = 1'b0, dec_ready;
  logic rd_valid, rd_ready = 1'b0, rd_last, rd_layer;
  logic [HIT_W-1:0] rd_hit;

  stub_correlator #(
    .COL_W(COL_W), .ROW_W(ROW_W), .WIN(WIN), .BUF_DEPTH(DEPTH)
  ) i_stub_correlator (
    .clk(clk), .rst_n(rst_n), .bypass(bypass),
    .inr_valid(inr_valid), .inr_ready(inr_ready), .inr_eoc(inr_eoc), .inr_hit(inr_hit),
    .otr_valid(otr_valid), .otr_ready(otr_ready), .otr_eoc(otr_eoc), .otr_hit(otr_hit),
    .trg_valid(trg_valid), .trg_ready(trg_ready), .trg_kind(trg_kind),
    .trg_inner(trg_inner), .trg_outer(trg_outer),
    .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_keep(dec_keep),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_last(rd_last),
    .rd_layer(rd_layer), .rd_hit(rd_hit)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit sink_rand = 1'b1;

  trg_exp_t exp_trg[$];
  rd_exp_t  exp_rd[$];
  logic [HIT_W:0] inr_q[$];
  logic [HIT_W:0] otr_q[$];
  logic keep_q[$];
  logic [HIT_W-1:0] ci[$];
  logic [HIT_W-1:0] co[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int col(input logic [HIT_W-1:0] h);
    return int'(h[HIT_W-1 -: COL_W]);
  endfunction

  function automatic logic [HIT_W-1:0] mk(input int c, input int r);
    logic [COL_W-1:0] cc = COL_W'(c);
    logic [ROW_W-1:0] rr = ROW_W'(r);
    return {cc, rr};
  endfunction

  // Reference walk from the requirements; fills the scoreboard queues.
  task automatic add_crossing(input bit keep, input bit byp, input string ptag,
                              input string stag, input string etag);
    int i = 0;
    int o = 0;
    logic [HIT_W:0] cons[$];
    trg_exp_t t;
    rd_exp_t  r;
    foreach (ci[k]) inr_q.push_back({1'b0, ci[k]});
    inr_q.push_back({1'b1, {HIT_W{1'b0}}});
    foreach (co[k]) otr_q.push_back({1'b0, co[k]});
    otr_q.push_back({1'b1, {HIT_W{1'b0}}});
    while (i < ci.size() || o < co.size()) begin
      bit take_in;
      if (i >= ci.size()) take_in = 1'b0;
      else if (o >= co.size()) take_in = 1'b1;
      else if (byp) take_in = !(col(co[o]) < col(ci[i]));
      else if (col(co[o]) > col(ci[i]) + WIN) take_in = 1'b1;
      else if (col(co[o]) + WIN < col(ci[i])) take_in = 1'b0;
      else begin
        t.kind = KIND_PAIR; t.hi = ci[i]; t.ho = co[o]; t.tag = ptag;
        exp_trg.push_back(t);
        take_in = 1'b1;
      end
      if (take_in) begin
        if (byp) begin
          t.kind = KIND_INNER; t.hi = ci[i]; t.ho = '0; t.tag = stag;
          exp_trg.push_back(t);
        end
        cons.push_back({1'b0, ci[i]});
        i++;
      end else begin
        if (byp) begin
          t.kind = KIND_OUTER; t.hi = '0; t.ho = co[o]; t.tag = stag;
          exp_trg.push_back(t);
        end
        cons.push_back({1'b1, co[o]});
        o++;
      end
    end
    t.kind = KIND_END; t.hi = '0; t.ho = '0; t.tag = etag;
    exp_trg.push_back(t);
    keep_q.push_back(keep);
    if (keep) begin
      foreach (cons[k]) begin
        r.last = 1'b0; r.layer = cons[k][HIT_W]; r.hit = cons[k][HIT_W-1:0]; r.tag = "R10";
        exp_rd.push_back(r);
      end
      r.last = 1'b1; r.layer = 1'b0; r.hit = '0; r.tag = "R11";
      exp_rd.push_back(r);
    end
    ci.delete();
    co.delete();
  endtask

  task automatic gen_lists(input int nmin, input int nspan);
    int n;
    int c;
    n = nmin + int'($urandom % nspan);
    c = int'($urandom % 16);
    for (int k = 0; k < n; k++) begin
      c += int'($urandom % 3);
      ci.push_back(mk(c, int'($urandom % 1024)));
    end
    n = nmin + int'($urandom % nspan);
    c = int'($urandom % 16);
    for (int k = 0; k < n; k++) begin
      c += int'($urandom % 3);
      co.push_back(mk(c, int'($urandom % 1024)));
    end
  endtask

  task automatic drive_inner();
    while (inr_q.size() > 0) begin
      inr_valid = 1'b1;
      {inr_eoc, inr_hit} = inr_q[0];
      @(negedge clk);
      while (!inr_ready) @(negedge clk);
      @(posedge clk); #1;
      void'(inr_q.pop_front());
      if ($urandom % 5 == 0) begin
        inr_valid = 1'b0;
        @(posedge clk); #1;
      end
    end
    inr_valid = 1'b0;
  endtask

  task automatic drive_outer();
    while (otr_q.size() > 0) begin
      otr_valid = 1'b1;
      {otr_eoc, otr_hit} = otr_q[0];
      @(negedge clk);
      while (!otr_ready) @(negedge clk);
      @(posedge clk); #1;
      void'(otr_q.pop_front());
      if ($urandom % 5 == 0) begin
        otr_valid = 1'b0;
        @(posedge clk); #1;
      end
    end
    otr_valid = 1'b0;
  endtask

  task automatic drive_dec(input int delay);
    repeat (delay) @(posedge clk);
    #1;
    while (keep_q.size() > 0) begin
      dec_valid = 1'b1;
      dec_keep  = keep_q[0];
      @(negedge clk);
      while (!dec_ready) @(negedge clk);
      @(posedge clk); #1;
      void'(keep_q.pop_front());
    end
    dec_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((exp_trg.size() > 0 || exp_rd.size() > 0) && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    check(exp_trg.size() == 0, "R6", "trigger beats missing", 64'(exp_trg.size()), 64'd0);
    check(exp_rd.size() == 0, "R10", "readout beats missing", 64'(exp_rd.size()), 64'd0);
  endtask

  task automatic run_phase(input int dec_delay);
    fork
      drive_inner();
      drive_outer();
      drive_dec(dec_delay);
    join
    drain();
  endtask

  // Random sink back-pressure.
  always @(posedge clk) begin
    #1;
    trg_ready = sink_rand ? ($urandom % 4 != 0) : 1'b1;
    rd_ready  = sink_rand ? ($urandom % 3 != 0) : 1'b1;
  end

  // Monitor: hold rule and scoreboard compare.
  logic p_v = 1'b0, p_r = 1'b0;
  logic [1:0] p_k = '0;
  logic [HIT_W-1:0] p_i = '0, p_o = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_v && !p_r)
        check(trg_valid && trg_kind == p_k && trg_inner == p_i && trg_outer == p_o,
              "R9", "held trigger beat changed",
              {trg_valid, trg_kind, trg_inner, trg_outer}, {1'b1, p_k, p_i, p_o});
      p_v = trg_valid; p_r = trg_ready; p_k = trg_kind; p_i = trg_inner; p_o = trg_outer;
      if (trg_valid && trg_ready) begin
        if (exp_trg.size() == 0)
          check(1'b0, "R1", "unexpected trigger beat", {trg_kind, trg_inner, trg_outer}, 64'd0);
        else begin
          trg_exp_t e;
          e = exp_trg.pop_front();
          check(trg_kind == e.kind && trg_inner == e.hi && trg_outer == e.ho, e.tag,
                "trigger beat", {trg_kind, trg_inner, trg_outer}, {e.kind, e.hi, e.ho});
        end
      end
      if (rd_valid && rd_ready) begin
        if (exp_rd.size() == 0)
          check(1'b0, "R11", "unexpected readout beat", {rd_last, rd_layer, rd_hit}, 64'd0);
        else begin
          rd_exp_t e;
          e = exp_rd.pop_front();
          check(rd_last == e.last && rd_layer == e.layer && rd_hit == e.hit, e.tag,
                "readout beat", {rd_last, rd_layer, rd_hit}, {e.last, e.layer, e.hit});
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      total++;
      bad++;
      $display("FAIL R9 watchdog expired actual=%0d expected<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    // R13: reset state, with both streams offering end markers
    inr_valid = 1'b1; inr_eoc = 1'b1; otr_valid = 1'b1; otr_eoc = 1'b1;
    repeat (3) @(negedge clk);
    check(!trg_valid, "R13", "trigger valid in reset", 64'(trg_valid), 64'd0);
    check(!rd_valid, "R13", "readout valid in reset", 64'(rd_valid), 64'd0);
    check(!inr_ready && !otr_ready, "R13", "input ready in reset",
          {inr_ready, otr_ready}, 64'd0);
    inr_valid = 1'b0; otr_valid = 1'b0; inr_eoc = 1'b0; otr_eoc = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    repeat (2) @(posedge clk); #1;

    // Directed correlation cases
    ci.push_back(mk(2, 7)); ci.push_back(mk(9, 1)); co.push_back(mk(8, 3));
    add_crossing(1'b1, 1'b0, "R1", "R7", "R1");
    ci.push_back(mk(10, 4)); co.push_back(mk(4, 5)); co.push_back(mk(9, 6));
    add_crossing(1'b1, 1'b0, "R2", "R7", "R2");
    ci.push_back(mk(4, 2)); ci.push_back(mk(5, 3)); co.push_back(mk(5, 9));
    add_crossing(1'b1, 1'b0, "R3", "R7", "R3");
    ci.push_back(mk(20, 0)); co.push_back(mk(22, 0));
    add_crossing(1'b0, 1'b0, "R4", "R7", "R4");
    ci.push_back(mk(30, 1)); co.push_back(mk(31, 2));
    ci.push_back(mk(40, 1)); co.push_back(mk(39, 2));
    add_crossing(1'b1, 1'b0, "R4", "R7", "R4");
    ci.push_back(mk(5, 1000)); co.push_back(mk(6, 3));
    add_crossing(1'b1, 1'b0, "R8", "R7", "R8");
    ci.push_back(mk(1, 1)); ci.push_back(mk(2, 2)); ci.push_back(mk(3, 3));
    add_crossing(1'b1, 1'b0, "R3", "R7", "R5");
    add_crossing(1'b1, 1'b0, "R3", "R7", "R11");
    run_phase(5);

    // Random correlation with back-pressure and mixed decisions
    for (int x = 0; x < 40; x++) begin
      gen_lists(0, 9);
      add_crossing(1'($urandom % 2), 1'b0, "R3", "R7", "R6");
    end
    run_phase(20);

    // Bypass: directed tie and tail, then random
    bypass = 1'b1;
    @(posedge clk); #1;
    ci.push_back(mk(7, 1)); co.push_back(mk(7, 2)); co.push_back(mk(3, 0));
    co.delete(); co.push_back(mk(3, 0)); co.push_back(mk(7, 2));
    add_crossing(1'b1, 1'b1, "R3", "R7", "R7");
    co.push_back(mk(4, 4)); co.push_back(mk(5, 5));
    add_crossing(1'b1, 1'b1, "R3", "R5", "R5");
    for (int x = 0; x < 20; x++) begin
      gen_lists(0, 9);
      add_crossing(1'($urandom % 2), 1'b1, "R3", "R7", "R6");
    end
    run_phase(10);
    bypass = 1'b0;
    @(posedge clk); #1;

    // Buffer fill: decisions held back until the buffer is full
    for (int x = 0; x < 50; x++) begin
      gen_lists(6, 3);
      add_crossing(1'($urandom % 2), 1'b0, "R3", "R7", "R6");
    end
    fork
      drive_inner();
      drive_outer();
      drive_dec(3000);
      begin
        bit moved = 1'b0;
        repeat (2500) @(negedge clk);
        for (int k = 0; k < 200; k++) begin
          if (inr_ready || otr_ready || !inr_valid || !otr_valid) moved = 1'b1;
          @(negedge clk);
        end
        check(!moved, "R12", "walk not stalled on full buffer", 64'(moved), 64'd0);
      end
    join
    drain();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule